// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock (normally a VCO after front-end conditioning) by a programmable ratio. It uses the pulse-swallow method. A dual-modulus prescaler divides by either P or P+1. Its output steps two counters: a 7-bit swallow counter and an 11-bit main counter. While the swallow counter is non-zero, the modulus-control signal holds the prescaler at P+1. After that the prescaler runs at P until the main counter expires. One output period is therefore P·N + A input clocks. At the end of each period the block emits a one-clock pulse `fp`, which a phase comparator would take as its feedback input.

The 18-bit setting (A and N) and the prescaler select bit arrive as static inputs from an external latch. The block samples them only at a period boundary, so changing them never produces a shortened or stretched period. A setting outside the legal range is clamped, and a sticky error flag records it. The flag stays set until reset.

Top module: `pswal_divider`

## Requirements
- R1: With `p_sel` = 0 the base ratio P is 64, and the number of input clocks from one rising `fp` to the next equals 64·N + A.
- R2: With `p_sel` = 1 the base ratio P is 128, and the period is 128·N + A input clocks.
- R3: With A = 0 every prescaler cycle uses ratio P, so the period is P·N and `mod_ctl` stays low for the whole period.
- R4: With A = N every prescaler cycle uses ratio P+1, so the period is (P+1)·N.
- R5: If A > N at a boundary, the block uses A = N for the next period and sets `cfg_err`.
- R6: If N < 16 at a boundary, the block uses N = 16 for the next period (A is then clamped against 16) and sets `cfg_err`.
- R7: `cfg_err` stays high once set, including through later legal settings, and only reset clears it.
- R8: The block samples A, N and `p_sel` only in the clock cycle whose edge ends a period. A change made partway through a period does not alter that period.
- R9: `fp` is high for exactly one input clock per period.
- R10: Within each period, `mod_ctl` is high for exactly A·(P+1) input clocks, and these are the first clocks of the period (the first A prescaler cycles). It rises only at the start of a period.
- R11: While `rst_n` is low, `fp`, `mod_ctl` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| swal_a | input | 7 | Swallow count A (0 to 127) |
| main_n | input | 11 | Main count N (16 to 2047) |
| p_sel | input | 1 | Prescaler base select: 0 gives 64/65, 1 gives 128/129 |
| fp | output | 1 | One-clock pulse per divided period |
| mod_ctl | output | 1 | Modulus control: high while the prescaler divides by P+1 |
| cfg_err | output | 1 | Sticky flag for a clamped setting |

## Verification
`fp` is registered: it rises in the clock that follows the edge closing a period. The settings sampled at that same edge are already in force during the `fp` cycle. `mod_ctl` and `cfg_err` are updated on that edge as well. The monitor therefore treats the `fp` cycle as the first clock of a new period, counting both clocks and high `mod_ctl` clocks from that cycle up to the next `fp`. The driver pushes the expected values only after it has seen the `fp` that captured the setting, and checks `cfg_err` in that same cycle. The driver changes settings twenty clocks into a period, well before any boundary, so each measured period reflects exactly one setting.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  parameter int unsigned A_W = 7;
  parameter int unsigned N_W = 11;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [N_W-1:0] n;
    logic           sel;
  } pswal_cfg_t;
endpackage

// File: rtl/pswal_rst_sync.sv
module pswal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pswal_cfg_latch.sv
module pswal_cfg_latch
  import pswal_pkg::*;
#(
  parameter int unsigned N_MIN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_i,
  input  logic [N_W-1:0] n_i,
  input  logic           sel_i,
  output logic [A_W-1:0] a_eff,
  output logic [N_W-1:0] n_eff,
  output logic           sel_q,
  output logic           err_q
);
  localparam logic [N_W-1:0] NMIN_V = N_W'(N_MIN);

  pswal_cfg_t cfg_q, cfg_d;
  logic       err_d;
  logic       n_low, a_high;

  // Clamp the incoming setting to its legal range.
  always_comb begin
    n_low  = (n_i < NMIN_V);
    n_eff  = n_low ? NMIN_V : n_i;
    a_high = (N_W'(a_i) > n_eff);
    a_eff  = a_high ? n_eff[A_W-1:0] : a_i;
  end

  // Next-state: capture only on a boundary; the error flag is sticky.
  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (load) begin
      cfg_d.a   = a_eff;
      cfg_d.n   = n_eff;
      cfg_d.sel = sel_i;
      err_d     = err_q | n_low | a_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign sel_q = cfg_q.sel;
endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
  parameter int unsigned P_LO = 64,
  parameter int unsigned P_HI = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel,
  input  logic mc,
  output logic tick
);
  localparam int unsigned PC_W = $clog2(P_HI + 1);

  logic [PC_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] last;

  // Terminal count: base-1 for ratio P, base for ratio P+1.
  always_comb begin
    base = sel ? PC_W'(P_HI) : PC_W'(P_LO);
    last = mc ? base : base - 1'b1;
    tick = en && (cnt_q == last);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pswal_counters.sv
module pswal_counters
  import pswal_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           tick,
  input  logic [A_W-1:0] a_ld,
  input  logic [N_W-1:0] n_ld,
  output logic           mc,
  output logic           term
);
  logic [N_W-1:0] main_q, main_d;
  logic [A_W-1:0] swal_q, swal_d;

  always_comb begin
    main_d = main_q;
    swal_d = swal_q;
    if (load) begin
      main_d = n_ld;
      swal_d = a_ld;
    end else if (tick) begin
      main_d = main_q - 1'b1;
      if (swal_q != '0) swal_d = swal_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      swal_q <= '0;
    end else begin
      main_q <= main_d;
      swal_q <= swal_d;
    end
  end

  assign mc   = (swal_q != '0);
  assign term = (main_q == N_W'(1));
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
  import pswal_pkg::*;
#(
  parameter int unsigned P_LO  = 64,
  parameter int unsigned P_HI  = 128,
  parameter int unsigned N_MIN = 16
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic [A_W-1:0] swal_a,
  input  logic [N_W-1:0] main_n,
  input  logic           p_sel,
  output logic           fp,
  output logic           mod_ctl,
  output logic           cfg_err
);
  logic           rst_sync_n;
  logic           armed_q, armed_d;
  logic           fp_q, fp_d;
  logic           tick, term, load, boundary;
  logic [A_W-1:0] a_eff;
  logic [N_W-1:0] n_eff;
  logic           sel_q;

  pswal_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk_in), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pswal_cfg_latch #(.N_MIN(N_MIN)) u_cfg (
    .clk(clk_in), .rst_n(rst_sync_n), .load(load),
    .a_i(swal_a), .n_i(main_n), .sel_i(p_sel),
    .a_eff(a_eff), .n_eff(n_eff), .sel_q(sel_q), .err_q(cfg_err)
  );

  pswal_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk(clk_in), .rst_n(rst_sync_n), .en(armed_q),
    .sel(sel_q), .mc(mod_ctl), .tick(tick)
  );

  pswal_counters u_cnt (
    .clk(clk_in), .rst_n(rst_sync_n), .load(load), .tick(tick),
    .a_ld(a_eff), .n_ld(n_eff), .mc(mod_ctl), .term(term)
  );

  // The first cycle out of reset loads the setting, and every later
  // boundary reloads it.
  always_comb begin
    boundary = tick && term;
    load     = !armed_q || boundary;
    armed_d  = 1'b1;
    fp_d     = boundary;
  end

  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed_q <= 1'b0;
      fp_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      fp_q    <= fp_d;
    end
  end

  assign fp = fp_q;
endmodule

// File: rtl/pswal_divider_chk.sv
module pswal_divider_chk
  import pswal_pkg::*;
#(
  parameter int unsigned N_MIN = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fp,
  input logic           mod_ctl,
  input logic           cfg_err,
  input logic           armed,
  input logic [A_W-1:0] a_i,
  input logic [N_W-1:0] n_i
);
  p_fp_one_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_clamp_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fp && (N_W'($past(a_i)) > $past(n_i))) |-> cfg_err);

  p_nmin_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fp && ($past(n_i) < N_W'(N_MIN))) |-> cfg_err);

  p_mc_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fp |-> (mod_ctl == ($past(a_i) != '0)));

  p_mc_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_ctl) |-> (fp || $rose(armed)));
endmodule

bind pswal_divider pswal_divider_chk #(.N_MIN(N_MIN)) u_chk (
  .clk(clk_in), .rst_n(rst_sync_n), .fp(fp), .mod_ctl(mod_ctl),
  .cfg_err(cfg_err), .armed(armed_q), .a_i(swal_a), .n_i(main_n)
);

// File: tb/sim_pswal_divider.sv
module sim_pswal_divider;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    ratio;
    int    mch;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  swal_a;
  logic [10:0] main_n;
  logic        p_sel;
  logic        fp, mod_ctl, cfg_err;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   exp_err = 0;
  exp_t q[$];

  pswal_divider u0 (
    .clk_in(clk), .rst_n(rst_n), .swal_a(swal_a), .main_n(main_n),
    .p_sel(p_sel), .fp(fp), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: change the setting mid-period (R8), wait for the boundary that
  // captures it, then push the expected period it produces.
  task automatic run_cfg(input int a, input int n, input int sel, input string tag);
    int p, ne, ae;
    exp_t e;
    repeat (20) @(negedge clk);
    swal_a = 7'(a); main_n = 11'(n); p_sel = sel[0];
    do @(negedge clk); while (!fp);
    p  = sel ? 128 : 64;
    ne = (n < 16) ? 16 : n;
    ae = (a > ne) ? ne : a;
    if (n < 16 || a > ne) exp_err = 1;
    e.ratio = p * ne + ae;
    e.mch   = ae * (p + 1);
    e.tag   = tag;
    q.push_back(e);
    check(cfg_err == exp_err, {tag, " cfg_err R5/R6/R7"}, cfg_err, exp_err);
  endtask

  // Monitor: measure clocks and mod_ctl-high clocks per period.
  initial begin
    bit have_prev = 0;
    bit prev_fp = 0;
    int cnt = 0, mcc = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        have_prev = 0; prev_fp = 0; cnt = 0; mcc = 0;
        q.delete();
      end else if (fp) begin
        check(!prev_fp, "R9 fp width", 2, 1);
        if (have_prev) begin
          if (q.size() == 0) begin
            check(0, "scoreboard empty", 0, 1);
          end else begin
            e = q.pop_front();
            check(cnt == e.ratio, {e.tag, " period"}, cnt, e.ratio);
            check(mcc == e.mch, {e.tag, " R10 mod_ctl clocks"}, mcc, e.mch);
          end
        end
        have_prev = 1; prev_fp = 1; cnt = 1; mcc = int'(mod_ctl);
      end else begin
        prev_fp = 0; cnt++; mcc += int'(mod_ctl);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; swal_a = 7'd0; main_n = 11'd16; p_sel = 1'b0;
    repeat (5) @(negedge clk);
    check(fp == 0, "R11 fp", fp, 0);
    check(mod_ctl == 0, "R11 mod_ctl", mod_ctl, 0);
    check(cfg_err == 0, "R11 cfg_err", cfg_err, 0);
    rst_n = 1'b1;

    run_cfg(10, 20, 0, "R1");
    run_cfg(37, 100, 0, "R8");
    run_cfg(5, 30, 1, "R2");
    run_cfg(0, 16, 0, "R3");
    run_cfg(0, 16, 1, "R3");
    run_cfg(16, 16, 0, "R4");
    run_cfg(40, 40, 1, "R4");
    run_cfg(127, 40, 1, "R5");
    run_cfg(3, 5, 0, "R6");
    run_cfg(10, 20, 0, "R7");
    run_cfg(10, 20, 0, "R7");

    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(fp == 0, "R11 fp again", fp, 0);
    check(mod_ctl == 0, "R11 mod_ctl again", mod_ctl, 0);
    check(cfg_err == 0, "R7 cleared by reset", cfg_err, 0);
    exp_err = 0;
    rst_n = 1'b1;
    run_cfg(2, 17, 0, "R1");
    run_cfg(2, 17, 0, "R1");
    run_cfg(2, 17, 0, "R1");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule